// File: doc/BRIEF.md
# Serial Flash Command Sequencer

This block runs one short serial flash command, described by a single 32-bit control word. A command always begins with an opcode byte. It can then carry a 1 to 4 byte address, up to 8 bytes of write data, up to 31 idle dummy clocks, and up to 8 bytes of returned data. Software first loads the address word and the two write-data words. It then writes the control word with its start bit set, and polls the busy bit in the control readback until it clears. The returned bytes are then read from two 32-bit read-data words.

The serial side is a single-lane SPI master in mode 0. SCLK idles low. MOSI changes while SCLK is low, and MISO is sampled at the rising SCLK edge. Chip select, active low, covers the whole command. One SCLK period lasts `2*HALF_CYC` system clocks.

Top module: `flash_cmd_engine`

## Requirements
- R1: After reset, the control readback and both read-data words are zero, chip select is high, and SCLK and MOSI are low.
- R2: The control word fields are: opcode in bits 31:24, read enable in bit 23, read count-1 in 22:20, address enable in bit 19, address count-1 in 17:16, write enable in bit 15, write count-1 in 14:12, and dummy clocks in 11:7. Writing bit 0 as 1 while idle starts a command. The readback returns the stored fields, with bit 1 showing busy, and bits 0, 6:2 and 18 reading as zero. A write with bit 0 clear only stores the fields.
- R3: The phases run in a fixed order: opcode, address, write data, dummy, read data. A disabled phase, or a dummy count of zero, is skipped.
- R4: The opcode is shifted out MSB first.
- R5: The address phase sends count bytes from the address word, most significant byte first, taken from bits count*8-1 down to 0. Three bytes use bits 23:0 and four bytes use bits 31:0.
- R6: Write byte k comes from the lower write word for k<4 and from the upper word for k>=4, at bit (k mod 4)*8. Byte 0 goes first, and each byte is sent MSB first.
- R7: The dummy phase gives the programmed number of SCLK pulses with MOSI low.
- R8: MISO is sampled at each rising SCLK edge in the read phase. Received byte k, MSB first on the wire, is stored at bit (k mod 4)*8 of the lower read word (k<4) or of the upper read word (k>=4).
- R9: Both read words are cleared when a command starts, so byte positions that were not received read as zero.
- R10: SCLK is low whenever chip select is high. The number of SCLK pulses in a command is 8 + 8*address bytes + 8*write bytes + dummy + 8*read bytes.
- R11: Chip select goes low when the command starts and rises exactly once, after the last bit. Busy clears on the cycle after that rise.
- R12: Writes to the control, address or write-data words while busy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 32 | Control word write value |
| ctl_rdata | output | 32 | Control readback with busy in bit 1 |
| addr_we | input | 1 | Address word write strobe |
| addr_wdata | input | 32 | Address word write value |
| wlo_we | input | 1 | Lower write-data word strobe |
| wlo_wdata | input | 32 | Lower write-data word value (bytes 0..3) |
| whi_we | input | 1 | Upper write-data word strobe |
| whi_wdata | input | 32 | Upper write-data word value (bytes 4..7) |
| rlo_rdata | output | 32 | Lower read-data word (bytes 0..3) |
| rhi_rdata | output | 32 | Upper read-data word (bytes 4..7) |
| spi_sclk | output | 1 | Serial clock, mode 0 |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |

## Verification
Some rules are checked on every cycle by assertions. Chip select stays high and SCLK stays low while idle. Busy follows a start on the next cycle and clears one cycle after chip select rises. The read words are zero right after a start. The phase order does not go back after the dummy phase. The control fields stay unchanged through a write made while busy. Other behaviour shows only in the bench scenarios, which compare against values worked out from the control word. These are the actual bit stream on MOSI (byte order, address width, dummy zeros), the exact SCLK pulse count, the placement of received bytes, and the zeroing of unread positions.

// File: rtl/fce_pkg.sv
package fce_pkg;

   localparam int WORD_W = 32;
   localparam int IDX_W  = 6;
   // control bits that are stored and read back
   localparam logic [WORD_W-1:0] CTL_KEEP = 32'hFFFB_FF80;

   typedef enum logic [2:0] {
      PH_IDLE, PH_OPC, PH_ADR, PH_WRD, PH_DMY, PH_RDD, PH_END
   } phase_e;

   typedef struct packed {
      logic [7:0] opcode;
      logic       rd_en;
      logic [2:0] rd_cnt;
      logic       ad_en;
      logic [1:0] ad_cnt;
      logic       wr_en;
      logic [2:0] wr_cnt;
      logic [4:0] dummy;
   } cmd_s;

   function automatic cmd_s unpack_ctl(input logic [WORD_W-1:0] w);
      cmd_s c;
      c.opcode = w[31:24];
      c.rd_en  = w[23];
      c.rd_cnt = w[22:20];
      c.ad_en  = w[19];
      c.ad_cnt = w[17:16];
      c.wr_en  = w[15];
      c.wr_cnt = w[14:12];
      c.dummy  = w[11:7];
      return c;
   endfunction

   function automatic phase_e after_phase(input phase_e cur, input cmd_s c);
      phase_e n;
      case (cur)
         PH_IDLE: n = PH_OPC;
         PH_OPC:  n = c.ad_en ? PH_ADR : c.wr_en ? PH_WRD :
                      (c.dummy != 5'd0) ? PH_DMY : c.rd_en ? PH_RDD : PH_END;
         PH_ADR:  n = c.wr_en ? PH_WRD : (c.dummy != 5'd0) ? PH_DMY :
                      c.rd_en ? PH_RDD : PH_END;
         PH_WRD:  n = (c.dummy != 5'd0) ? PH_DMY : c.rd_en ? PH_RDD : PH_END;
         PH_DMY:  n = c.rd_en ? PH_RDD : PH_END;
         PH_RDD:  n = PH_END;
         default: n = PH_IDLE;
      endcase
      return n;
   endfunction

   function automatic logic [IDX_W-1:0] phase_last(input phase_e p, input cmd_s c);
      logic [IDX_W-1:0] v;
      case (p)
         PH_OPC:  v = 6'd7;
         PH_ADR:  v = {1'b0, c.ad_cnt, 3'b111};
         PH_WRD:  v = {c.wr_cnt, 3'b111};
         PH_DMY:  v = {1'b0, c.dummy} - 6'd1;
         PH_RDD:  v = {c.rd_cnt, 3'b111};
         default: v = 6'd0;
      endcase
      return v;
   endfunction

endpackage

// File: rtl/fce_regs.sv
module fce_regs
   import fce_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              busy,
   input  logic              ctl_we,
   input  logic [WORD_W-1:0] ctl_wdata,
   input  logic              addr_we,
   input  logic [WORD_W-1:0] addr_wdata,
   input  logic              wlo_we,
   input  logic [WORD_W-1:0] wlo_wdata,
   input  logic              whi_we,
   input  logic [WORD_W-1:0] whi_wdata,
   output logic              start,
   output cmd_s              cmd,
   output logic [WORD_W-1:0] addr_q,
   output logic [2*WORD_W-1:0] wdata_q,
   output logic [WORD_W-1:0] ctl_rdata
);

   logic [WORD_W-1:0] ctl_q;

   assign start = ctl_we && ctl_wdata[0] && !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q   <= '0;
         addr_q  <= '0;
         wdata_q <= '0;
      end else if (!busy) begin
         if (ctl_we)  ctl_q <= ctl_wdata & CTL_KEEP;
         if (addr_we) addr_q <= addr_wdata;
         if (wlo_we)  wdata_q[WORD_W-1:0] <= wlo_wdata;
         if (whi_we)  wdata_q[2*WORD_W-1:WORD_W] <= whi_wdata;
      end
   end

   assign cmd       = unpack_ctl(ctl_q);
   assign ctl_rdata = ctl_q | {{(WORD_W-2){1'b0}}, busy, 1'b0};

   // R12: control fields hold through a write made while busy
   assert_busy_write_ignored_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && ctl_we) |=> $stable(ctl_rdata[WORD_W-1:2]));

endmodule

// File: rtl/fce_bit_clock.sv
module fce_bit_clock #(
   parameter int HALF_CYC = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic half_hi,
   output logic tick_rise,
   output logic tick_fall
);

   logic last;

   if (HALF_CYC < 1) begin : g_bad_half
      $error("HALF_CYC must be at least 1");
   end

   if (HALF_CYC == 1) begin : g_fast
      assign last = 1'b1;
   end else begin : g_div
      localparam int CNT_W = $clog2(HALF_CYC);
      logic [CNT_W-1:0] cnt;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      cnt <= '0;
         else if (!run)   cnt <= '0;
         else if (last)   cnt <= '0;
         else             cnt <= cnt + 1'b1;
      end
      assign last = (cnt == CNT_W'(HALF_CYC - 1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      half_hi <= 1'b0;
      else if (!run)   half_hi <= 1'b0;
      else if (last)   half_hi <= ~half_hi;
   end

   assign tick_rise = run && !half_hi && last;
   assign tick_fall = run &&  half_hi && last;

   // R10: clock returns low as soon as shifting stops
   assert_sclk_low_when_stopped_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> !half_hi);

endmodule

// File: rtl/fce_rx_store.sv
module fce_rx_store
   import fce_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              cap,
   input  logic [IDX_W-1:0]  pos,
   input  logic              din,
   output logic [WORD_W-1:0] lo,
   output logic [WORD_W-1:0] hi
);

   logic [2*WORD_W-1:0] rx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    rx <= '0;
      else if (clr)  rx <= '0;
      else if (cap)  rx[pos] <= din;
   end

   assign lo = rx[WORD_W-1:0];
   assign hi = rx[2*WORD_W-1:WORD_W];

   // R9: a new command begins with empty read words
   assert_clear_on_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (lo == '0 && hi == '0));

endmodule

// File: rtl/fce_seq.sv
module fce_seq
   import fce_pkg::*;
(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  cmd_s                cmd,
   input  logic [WORD_W-1:0]   addr_q,
   input  logic [2*WORD_W-1:0] wdata_q,
   input  logic                tick_fall,
   output phase_e              phase,
   output logic [IDX_W-1:0]    idx,
   output logic                run,
   output logic                mosi
);

   logic [4:0] adr_pos;
   logic [IDX_W-1:0] byte_pos;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_IDLE;
         idx   <= '0;
      end else begin
         case (phase)
            PH_IDLE: begin
               idx <= '0;
               if (start) phase <= PH_OPC;
            end
            PH_END: phase <= PH_IDLE;
            default: begin
               if (tick_fall) begin
                  if (idx == phase_last(phase, cmd)) begin
                     phase <= after_phase(phase, cmd);
                     idx   <= '0;
                  end else begin
                     idx <= idx + 1'b1;
                  end
               end
            end
         endcase
      end
   end

   assign run      = (phase != PH_IDLE) && (phase != PH_END);
   assign adr_pos  = {cmd.ad_cnt, 3'b111} - idx[4:0];
   assign byte_pos = {idx[5:3], ~idx[2:0]};

   always_comb begin
      case (phase)
         PH_OPC:  mosi = cmd.opcode[~idx[2:0]];
         PH_ADR:  mosi = addr_q[adr_pos];
         PH_WRD:  mosi = wdata_q[byte_pos];
         default: mosi = 1'b0;
      endcase
   end

   // R3: nothing but read data or the end can follow the dummy phase
   assert_order_after_dummy_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_DMY && tick_fall) |=>
         (phase == PH_DMY || phase == PH_RDD || phase == PH_END));

endmodule

// File: rtl/flash_cmd_engine.sv
module flash_cmd_engine
   import fce_pkg::*;
#(
   parameter int HALF_CYC = 1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        ctl_we,
   input  logic [31:0] ctl_wdata,
   output logic [31:0] ctl_rdata,
   input  logic        addr_we,
   input  logic [31:0] addr_wdata,
   input  logic        wlo_we,
   input  logic [31:0] wlo_wdata,
   input  logic        whi_we,
   input  logic [31:0] whi_wdata,
   output logic [31:0] rlo_rdata,
   output logic [31:0] rhi_rdata,
   output logic        spi_sclk,
   output logic        spi_cs_n,
   output logic        spi_mosi,
   input  logic        spi_miso
);

   logic                start, busy, run, half_hi, tick_rise, tick_fall;
   cmd_s                cmd;
   logic [WORD_W-1:0]   addr_q;
   logic [2*WORD_W-1:0] wdata_q;
   phase_e              phase;
   logic [IDX_W-1:0]    idx;

   assign busy = (phase != PH_IDLE);

   fce_regs u_regs (
      .clk(clk), .rst_n(rst_n), .busy(busy),
      .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
      .addr_we(addr_we), .addr_wdata(addr_wdata),
      .wlo_we(wlo_we), .wlo_wdata(wlo_wdata),
      .whi_we(whi_we), .whi_wdata(whi_wdata),
      .start(start), .cmd(cmd), .addr_q(addr_q), .wdata_q(wdata_q),
      .ctl_rdata(ctl_rdata)
   );

   fce_bit_clock #(.HALF_CYC(HALF_CYC)) u_bit_clock (
      .clk(clk), .rst_n(rst_n), .run(run),
      .half_hi(half_hi), .tick_rise(tick_rise), .tick_fall(tick_fall)
   );

   fce_seq u_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .cmd(cmd),
      .addr_q(addr_q), .wdata_q(wdata_q), .tick_fall(tick_fall),
      .phase(phase), .idx(idx), .run(run), .mosi(spi_mosi)
   );

   fce_rx_store u_rx (
      .clk(clk), .rst_n(rst_n), .clr(start),
      .cap(tick_rise && phase == PH_RDD),
      .pos({idx[5:3], ~idx[2:0]}), .din(spi_miso),
      .lo(rlo_rdata), .hi(rhi_rdata)
   );

   assign spi_sclk = half_hi;
   assign spi_cs_n = (phase == PH_IDLE) || (phase == PH_END);

   // R11: chip select is high whenever the engine is idle
   assert_cs_high_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> spi_cs_n);
   // R11: release happens while busy, busy drops on the next cycle
   assert_release_then_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(spi_cs_n) |-> busy ##1 !busy);
   // R2: an accepted start shows busy and a selected device next cycle
   assert_start_sets_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (busy && !spi_cs_n));
   // R10: no clock pulse outside chip select
   assert_no_sclk_deselected_R10: assert property (@(posedge clk) disable iff (!rst_n)
      spi_cs_n |-> !spi_sclk);

endmodule

// File: tb/flash_cmd_engine_bench.sv
module flash_cmd_engine_bench;

   localparam int CLK_PERIOD = 10;
   localparam int NV = 6;

   // stimulus: control, address, write low, write high, device response, expected SCLK pulses
   localparam logic [31:0] T_CTL  [NV] = '{32'h9FA0_0001, 32'h0600_0001, 32'h020A_F001,
                                           32'h0BFB_0401, 32'h0580_0181, 32'h0108_9F81};
   localparam logic [31:0] T_ADDR [NV] = '{32'h0, 32'h0, 32'h00AB_CDEF,
                                           32'h1234_5678, 32'h0, 32'h0000_00C5};
   localparam logic [31:0] T_WLO  [NV] = '{32'h0, 32'h0, 32'h4433_2211,
                                           32'h0, 32'h0, 32'h0000_B7A6};
   localparam logic [31:0] T_WHI  [NV] = '{32'h0, 32'h0, 32'h8877_6655,
                                           32'h0, 32'h0, 32'h0};
   localparam logic [63:0] T_RESP [NV] = '{64'hEF40_18AA_BBCC_DDEE, 64'h0, 64'h0,
                                           64'h0102_0304_A5B6_C7D8, 64'h5C00_0000_0000_0000, 64'h0};
   localparam int          T_NCLK [NV] = '{32, 8, 96, 112, 19, 63};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   logic        ctl_we = 0, addr_we = 0, wlo_we = 0, whi_we = 0;
   logic [31:0] ctl_wdata = 0, addr_wdata = 0, wlo_wdata = 0, whi_wdata = 0;
   logic [31:0] ctl_rdata, rlo_rdata, rhi_rdata;
   logic        spi_sclk, spi_cs_n, spi_mosi, spi_miso;

   flash_cmd_engine #(.HALF_CYC(1)) u_flash_cmd_engine (
      .clk(clk), .rst_n(rst_n),
      .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
      .addr_we(addr_we), .addr_wdata(addr_wdata),
      .wlo_we(wlo_we), .wlo_wdata(wlo_wdata),
      .whi_we(whi_we), .whi_wdata(whi_wdata),
      .rlo_rdata(rlo_rdata), .rhi_rdata(rhi_rdata),
      .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
      .spi_mosi(spi_mosi), .spi_miso(spi_miso)
   );

   int checks = 0;
   int errors = 0;

   // device model: counts SCLK rises, records MOSI, answers from resp
   int           nrise = 0;
   int           cs_rises = 0;
   logic [127:0] cap = '0;
   int           base_rise = 0;
   int           skip = 1000;
   logic [63:0]  resp = '0;

   always @(posedge spi_sclk) begin
      nrise <= nrise + 1;
      cap   <= {cap[126:0], spi_mosi};
   end
   always @(posedge spi_cs_n) cs_rises = cs_rises + 1;

   always_comb begin
      int j;
      j = nrise - base_rise - skip;
      spi_miso = (j >= 0 && j < 64) ? resp[63-j] : 1'b0;
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic wr(input int sel, input logic [31:0] d);
      @(negedge clk);
      case (sel)
         0: begin ctl_we = 1; ctl_wdata = d; end
         1: begin addr_we = 1; addr_wdata = d; end
         2: begin wlo_we = 1; wlo_wdata = d; end
         default: begin whi_we = 1; whi_wdata = d; end
      endcase
      @(negedge clk);
      ctl_we = 0; addr_we = 0; wlo_we = 0; whi_we = 0;
   endtask

   task automatic run_cmd(input logic [31:0] ctl, input logic [31:0] adr,
                          input logic [31:0] wlo, input logic [31:0] whi,
                          input logic [63:0] r, input int nclk, input bit inject);
      int na, nw, nd, nr, nbits, t, rises0;
      logic [127:0] e, m;
      logic [63:0]  wd, rx;
      na = ctl[19] ? int'(ctl[17:16]) + 1 : 0;
      nw = ctl[15] ? int'(ctl[14:12]) + 1 : 0;
      nr = ctl[23] ? int'(ctl[22:20]) + 1 : 0;
      nd = int'(ctl[11:7]);
      nbits = 8 + 8*na + 8*nw + nd + 8*nr;
      wr(1, adr); wr(2, wlo); wr(3, whi);
      resp = r;
      base_rise = nrise;
      skip = 8 + 8*na + 8*nw + nd;
      rises0 = cs_rises;
      wr(0, ctl);
      chk(ctl_rdata[1] == 1'b1 && ctl_rdata[0] == 1'b0 && !spi_cs_n,
          "R2", "busy after start", ctl_rdata, {ctl[31:2], 2'b10});
      if (inject) begin
         wr(0, 32'hC3FF_FFFF);
         wr(1, 32'hFFFF_FFFF);
      end
      t = 0;
      while (ctl_rdata[1] && t < 5000) begin
         @(negedge clk);
         t++;
      end
      chk(t < 5000, "R2", "busy clears", t, 0);
      chk(nrise - base_rise == nclk && nclk == nbits, "R10", "sclk pulse count",
          nrise - base_rise, nclk);
      chk(cs_rises - rises0 == 1 && spi_cs_n, "R11", "single chip select release",
          cs_rises - rises0, 1);
      // expected wire stream (R3 order, R4 opcode, R5 address, R6 data, R7 dummy zeros)
      e = '0;
      e = {e[119:0], ctl[31:24]};
      for (int k = na - 1; k >= 0; k--) e = {e[119:0], adr[8*k +: 8]};
      wd = {whi, wlo};
      for (int k = 0; k < nw; k++) e = {e[119:0], wd[8*k +: 8]};
      e = e << (nd + 8*nr);
      m = (nbits >= 128) ? '1 : ((128'd1 << nbits) - 128'd1);
      chk((cap & m) == (e & m), "R3/R4/R5/R6/R7", "mosi stream", cap & m, e & m);
      rx = '0;
      for (int k = 0; k < nr; k++) rx[8*k +: 8] = r[63-8*k -: 8];
      chk(rlo_rdata == rx[31:0], "R8/R9", "read lower word", rlo_rdata, rx[31:0]);
      chk(rhi_rdata == rx[63:32], "R8/R9", "read upper word", rhi_rdata, rx[63:32]);
      chk(ctl_rdata == (ctl & 32'hFFFB_FF80), inject ? "R12" : "R2",
          "control readback", ctl_rdata, ctl & 32'hFFFB_FF80);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(ctl_rdata == 0, "R1", "control readback", ctl_rdata, 0);
      chk(spi_cs_n && !spi_sclk && !spi_mosi, "R1", "serial pins",
          {spi_cs_n, spi_sclk, spi_mosi}, 3'b100);
      chk(rlo_rdata == 0 && rhi_rdata == 0, "R1", "read words", {rhi_rdata, rlo_rdata}, 0);

      // R2 store without start
      wr(0, 32'h9FA0_0000);
      repeat (4) @(negedge clk);
      chk(spi_cs_n && ctl_rdata == 32'h9FA0_0000, "R2", "store only",
          ctl_rdata, 32'h9FA0_0000);

      // table walk
      for (int i = 0; i < NV; i++)
         run_cmd(T_CTL[i], T_ADDR[i], T_WLO[i], T_WHI[i], T_RESP[i], T_NCLK[i], 1'b0);

      // R12 writes during a command are dropped, stream uses old values
      run_cmd(T_CTL[2], T_ADDR[2], T_WLO[2], T_WHI[2], T_RESP[2], T_NCLK[2], 1'b1);
      repeat (4) @(negedge clk);
      chk(spi_cs_n && !ctl_rdata[1], "R12", "no restart from ignored write",
          ctl_rdata, T_CTL[2] & 32'hFFFB_FF80);

      // R9 short read after long read leaves zeros above
      run_cmd(T_CTL[3], T_ADDR[3], 0, 0, T_RESP[3], T_NCLK[3], 1'b0);
      run_cmd(T_CTL[4], 0, 0, 0, 64'hFF00_0000_0000_0000, T_NCLK[4], 1'b0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule